// File: doc/BRIEF.md
# DDR SDRAM Command Legality Monitor

This block sits beside the command bus of a four-bank double-data-rate SDRAM and judges every command the controller issues. On each rising clock edge it decodes chip select, RAS, CAS and WE into a command. It then compares that command with a small per-bank state model, and with global spacing rules, to find any command the memory would not accept. Illegal commands are reported and then discarded, so the model keeps following what the memory really does.

Each bank is modelled as idle, opening (activate issued, column access not yet allowed), open, closing (precharge in progress) or refreshing. All minimum delays are parameters counted in clock cycles. The outputs are a registered command code, the packed state of every bank, and a one-cycle error flag with a reason code. These outputs suit a simulation scoreboard or an on-chip protocol monitor.

Top module: `ddr_cmd_guard`

## Requirements
- R1: With CKE high and chip select low, RAS/CAS/WE decode as HHH NOP (code 1), HHL burst stop (2), HLH read (3), HLL write (4), LHH activate (5), LHL precharge (6), LLH refresh (7), LLL mode set (8). Chip select high is deselect (0). Burst stop, NOP and deselect are always legal.
- R2: A command sampled with CKE low is not checked and changes no bank state. It is reported as code 9 with no error.
- R3: A read or write to a bank that is not open is illegal. If the bank is opening, the reason is 2 (activate-to-column delay); otherwise the reason is 1 (bank state). An activate to a bank that is not idle has reason 1.
- R4: An activate moves its bank to opening, state code 1. The bank becomes open, code 2, so that a read or write issued T_RCD cycles after the activate is legal.
- R5: For a precharge, A8 high selects every bank and ignores BA; A8 low selects only bank BA. Selected open or opening banks go to closing, code 3, and are idle again (code 0) T_RP cycles after the precharge. A precharge of an idle bank is legal and has no effect.
- R6: A precharge that selects an open or opening bank fewer than T_RAS cycles after that bank's activate is illegal, with reason 3.
- R7: An activate fewer than T_RRD cycles after the last accepted activate is illegal, with reason 4.
- R8: Refresh and mode set are illegal, with reason 6, unless all banks are idle. A refresh puts every bank in refreshing (code 4), and an activate becomes legal T_RFC cycles later.
- R9: Any command other than NOP or deselect fewer than T_MRD cycles after an accepted mode set is illegal, with reason 5.
- R10: A read or write with A8 high (auto-precharge) to an open bank is legal and moves that bank to closing at once.
- R11: The error flag and reason appear registered, in the cycle after the command edge, together with its code. A rejected command changes no state. When several rules are broken, reason 5 wins over all others.
- R12: A synchronous active-low reset makes all banks idle, clears the error and clears all delay counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low means the command is unchecked |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a8 | input | 1 | All-bank select on precharge, auto-precharge on read/write |
| cmd_code | output | 4 | Registered decoded command (0..9) |
| bank_state | output | 12 | Bank b state in bits [3b+2:3b] |
| error | output | 1 | One-cycle pulse for an illegal command |
| error_reason | output | 3 | Reason code, 0 when no error |

## Verification
The bench checks the exact edge of every delay. It issues a command one cycle before each window ends and one at its end. An off-by-one counter would therefore flag the legal command or miss the early one. An all-bank precharge is issued while only one bank is inside its T_RAS window, and with a BA that names an idle bank. A design that honoured BA or checked only one bank would accept it. A read to an idle bank right after a mode set must report reason 5, which exposes a wrong priority order. Commands are also issued with CKE low and then followed by a state check, which catches a model that acts on inhibited cycles.

// File: rtl/ddrchk_pkg.sv
// Package: shared encodings for the DDR command legality monitor.
// Assumes: code values are visible at the top ports and must stay stable.
package ddrchk_pkg;

    typedef enum logic [3:0] {
        C_DESEL = 4'd0,
        C_NOP   = 4'd1,
        C_BST   = 4'd2,
        C_RD    = 4'd3,
        C_WR    = 4'd4,
        C_ACT   = 4'd5,
        C_PRE   = 4'd6,
        C_REF   = 4'd7,
        C_MRS   = 4'd8,
        C_OFF   = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE    = 3'd0,
        B_OPENING = 3'd1,
        B_OPEN    = 3'd2,
        B_CLOSING = 3'd3,
        B_REFRESH = 3'd4
    } bank_e;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_STATE = 3'd1,
        E_RCD   = 3'd2,
        E_RAS   = 3'd3,
        E_RRD   = 3'd4,
        E_MRD   = 3'd5,
        E_BUSY  = 3'd6
    } why_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Module: turns the raw command pins into a command code.
// Assumes: pins are already sampled-stable at the rising edge; CKE low
// marks the cycle as unchecked (C_OFF).
module ddr_cmd_decode
    import ddrchk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Truth table of the command pins.
    always_comb begin
        if (!cke) begin
            cmd = C_OFF;
        end else if (cs_n) begin
            cmd = C_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b110:  cmd = C_BST;
                3'b101:  cmd = C_RD;
                3'b100:  cmd = C_WR;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                default: cmd = C_MRS;
            endcase
        end
    end

endmodule

// File: rtl/ddr_gap_timer.sv
// Module: down-counter that stays busy until GAP cycles have passed
// since the last start pulse.
// Assumes: GAP >= 1; a start while busy restarts the window.
module ddr_gap_timer #(
    parameter int GAP = 2,
    parameter int CW  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam logic [CW-1:0] LOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_i) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

endmodule

// File: rtl/ddr_bank_track.sv
// Module: state model of one bank (idle/opening/open/closing/refreshing),
// with a phase counter and a separate minimum-row-open counter.
// Assumes: event inputs are already judged legal by the caller; a close
// request on a bank that is not open or opening is ignored.
module ddr_bank_track
    import ddrchk_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 8,
    parameter int T_RFC = 13,
    parameter int CW    = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  open_i,
    input  logic  close_i,
    input  logic  refresh_i,
    output bank_e state_o,
    output logic  ras_met_o
);

    localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 1);

    bank_e         st;
    logic [CW-1:0] phase_cnt;
    logic [CW-1:0] ras_cnt;

    // Row-open time: restart on activate, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_cnt <= '0;
        end else if (open_i) begin
            ras_cnt <= LD_RAS;
        end else if (ras_cnt != '0) begin
            ras_cnt <= ras_cnt - 1'b1;
        end
    end

    // Bank state and the counter that ends the timed phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= B_IDLE;
            phase_cnt <= '0;
        end else if (open_i) begin
            phase_cnt <= LD_RCD;
            st        <= (T_RCD <= 1) ? B_OPEN : B_OPENING;
        end else if (refresh_i) begin
            phase_cnt <= LD_RFC;
            st        <= (T_RFC <= 1) ? B_IDLE : B_REFRESH;
        end else if (close_i && (st == B_OPEN || st == B_OPENING)) begin
            phase_cnt <= LD_RP;
            st        <= (T_RP <= 1) ? B_IDLE : B_CLOSING;
        end else if (phase_cnt != '0) begin
            phase_cnt <= phase_cnt - 1'b1;
            if (phase_cnt == CW'(1)) begin
                st <= (st == B_OPENING) ? B_OPEN : B_IDLE;
            end
        end
    end

    assign state_o   = st;
    assign ras_met_o = (ras_cnt == '0);

endmodule

// File: rtl/ddr_cmd_guard.sv
// Module: top of the command legality monitor. Decodes each command,
// judges it against per-bank state and global spacing timers, updates
// the model only for legal commands and reports a registered result.
// Assumes: all timing parameters >= 1 cycle, counted from command edge
// to command edge; data path and power-down are not modelled.
module ddr_cmd_guard
    import ddrchk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 8,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                     a8,
    output logic [3:0]               cmd_code,
    output logic [NUM_BANKS*3-1:0]   bank_state,
    output logic                     error,
    output logic [2:0]               error_reason
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int T_M1  = (T_RCD > T_RP)  ? T_RCD : T_RP;
    localparam int T_M2  = (T_RAS > T_RFC) ? T_RAS : T_RFC;
    localparam int T_M3  = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int T_M12 = (T_M1 > T_M2)   ? T_M1  : T_M2;
    localparam int T_MAX = (T_M12 > T_M3)  ? T_M12 : T_M3;
    localparam int CW    = $clog2(T_MAX + 1);

    cmd_e                 cmd;
    bank_e                bst [NUM_BANKS];
    logic [NUM_BANKS-1:0] ras_met;
    logic [NUM_BANKS-1:0] open_ev;
    logic [NUM_BANKS-1:0] close_ev;
    logic                 refresh_ev;
    logic                 rrd_busy;
    logic                 mrd_busy;
    logic                 ok;
    why_e                 why;
    logic                 all_idle;
    logic                 any_refresh;
    logic                 all_ras_bad;
    bank_e                tgt;

    ddr_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_gap_timer #(.GAP(T_RRD), .CW(CW)) u_rrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ok && cmd == C_ACT),
        .busy_o  (rrd_busy)
    );

    ddr_gap_timer #(.GAP(T_MRD), .CW(CW)) u_mrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ok && cmd == C_MRS),
        .busy_o  (mrd_busy)
    );

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            ddr_bank_track #(
                .T_RCD (T_RCD),
                .T_RP  (T_RP),
                .T_RAS (T_RAS),
                .T_RFC (T_RFC),
                .CW    (CW)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .open_i    (open_ev[gb]),
                .close_i   (close_ev[gb]),
                .refresh_i (refresh_ev),
                .state_o   (bst[gb]),
                .ras_met_o (ras_met[gb])
            );
            assign bank_state[gb*3 +: 3] = bst[gb];
        end
    endgenerate

    // Summaries over all banks used by the all-bank rules.
    always_comb begin
        all_idle    = 1'b1;
        any_refresh = 1'b0;
        all_ras_bad = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bst[b] != B_IDLE)    all_idle    = 1'b0;
            if (bst[b] == B_REFRESH) any_refresh = 1'b1;
            if ((bst[b] == B_OPEN || bst[b] == B_OPENING) && !ras_met[b])
                all_ras_bad = 1'b1;
        end
    end

    assign tgt = bst[ba];

    // Legality judgement; spacing after mode set outranks all else.
    always_comb begin
        why = E_NONE;
        if (cmd != C_OFF && cmd != C_DESEL && cmd != C_NOP && mrd_busy) begin
            why = E_MRD;
        end else begin
            unique case (cmd)
                C_RD, C_WR: begin
                    if (tgt == B_OPENING)   why = E_RCD;
                    else if (tgt != B_OPEN) why = E_STATE;
                end
                C_ACT: begin
                    if (tgt != B_IDLE)  why = E_STATE;
                    else if (rrd_busy)  why = E_RRD;
                end
                C_PRE: begin
                    if (a8) begin
                        if (any_refresh)      why = E_STATE;
                        else if (all_ras_bad) why = E_RAS;
                    end else begin
                        if (tgt == B_REFRESH) why = E_STATE;
                        else if ((tgt == B_OPEN || tgt == B_OPENING) &&
                                 !ras_met[ba]) why = E_RAS;
                    end
                end
                C_REF, C_MRS: begin
                    if (!all_idle) why = E_BUSY;
                end
                default: why = E_NONE;
            endcase
        end
    end

    assign ok = (cmd != C_OFF) && (why == E_NONE);

    // Events handed to the bank models for accepted commands.
    always_comb begin
        refresh_ev = ok && (cmd == C_REF);
        for (int b = 0; b < NUM_BANKS; b++) begin
            open_ev[b]  = ok && (cmd == C_ACT) && (ba == BA_W'(b));
            close_ev[b] = ok && (
                ((cmd == C_PRE) && (a8 || ba == BA_W'(b))) ||
                ((cmd == C_RD || cmd == C_WR) && a8 && ba == BA_W'(b)));
        end
    end

    // Registered report of the command just judged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code     <= C_NOP;
            error        <= 1'b0;
            error_reason <= E_NONE;
        end else begin
            cmd_code     <= cmd;
            error        <= (why != E_NONE);
            error_reason <= why;
        end
    end

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
// Module: assertion checker bound to ddr_cmd_guard; observes its ports.
// Assumes: reason and state codes as listed in the requirements.
module ddr_cmd_guard_chk #(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_MRD     = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke,
    input logic [3:0]             cmd_code,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic                   error,
    input logic [2:0]             error_reason
);

    logic [NUM_BANKS-1:0] in_refresh;

    // Which banks currently report refreshing.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            in_refresh[b] = (bank_state[b*3 +: 3] == 3'd4);
    end

    // R11: a flagged command always carries a reason.
    a_r11_err_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (error_reason != 3'd0));

    // R11: no reason is shown without an error.
    a_r11_quiet_no_reason: assert property (@(posedge clk) disable iff (!rst_n)
        !error |-> (error_reason == 3'd0));

    // R2: an inhibited cycle is reported as code 9 with no error.
    a_r2_cke_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!error && cmd_code == 4'd9));

    // R8: refresh covers every bank or none.
    a_r8_refresh_together: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_refresh) == 0) || ($countones(in_refresh) == NUM_BANKS));

    generate
        if (T_MRD > 1) begin : g_mrd
            // R9: the command after an accepted mode set is idle or rejected.
            a_r9_mrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_code == 4'd8 && !error) |=>
                    (cmd_code == 4'd0 || cmd_code == 4'd1 ||
                     cmd_code == 4'd9 || error));
        end
        if (T_RCD > 1) begin : g_rcd
            for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
                // R4: an idle bank never jumps straight to open.
                a_r4_no_skip_open: assert property (@(posedge clk) disable iff (!rst_n)
                    (bank_state[b*3 +: 3] == 3'd0) |=> (bank_state[b*3 +: 3] != 3'd2));
            end
        end
    endgenerate

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RCD     (T_RCD),
    .T_MRD     (T_MRD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cmd_code     (cmd_code),
    .bank_state   (bank_state),
    .error        (error),
    .error_reason (error_reason)
);

// File: tb/test_ddr_cmd_guard.sv
// Scoreboard bench: the driver pushes the expected code/reason of every
// issued cycle; a monitor pops and compares one cycle later.
module test_ddr_cmd_guard;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a8 = 1'b0;
    logic [3:0]  cmd_code;
    logic [11:0] bank_state;
    logic        error;
    logic [2:0]  error_reason;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int    code;
        int    why;
        string req;
    } exp_t;

    exp_t sb[$];

    ddr_cmd_guard i_ddr_cmd_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke          (cke),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .a8           (a8),
        .cmd_code     (cmd_code),
        .bank_state   (bank_state),
        .error        (error),
        .error_reason (error_reason)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Issue one command for one cycle and record its expected report.
    task automatic iss(int code, int bnk, bit ap, int why, string req, bit ck = 1'b1);
        exp_t e;
        cke  = ck;
        cs_n = (code == 0);
        {ras_n, cas_n, we_n} = (code == 0) ? 3'b111 : 3'(8 - code);
        ba   = 2'(bnk);
        a8   = ap;
        e.code = ck ? code : 9;
        e.why  = why;
        e.req  = req;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++) iss(1, 0, 1'b0, 0, "R1");
    endtask

    task automatic st_chk(int bnk, int exp, string req);
        n_checks++;
        if (int'(bank_state[bnk*3 +: 3]) != exp) begin
            n_fails++;
            $display("FAIL %s bank %0d state actual=%0d expected=%0d",
                     req, bnk, bank_state[bnk*3 +: 3], exp);
        end
    endtask

    task automatic all_chk(logic [11:0] exp, string req);
        n_checks++;
        if (bank_state !== exp) begin
            n_fails++;
            $display("FAIL %s bank_state actual=%h expected=%h", req, bank_state, exp);
        end
    endtask

    // Monitor: compare the report of the command taken at this edge.
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (int'(cmd_code) != e.code || int'(error_reason) != e.why ||
                error != (e.why != 0)) begin
                n_fails++;
                $display("FAIL %s code/err/reason actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                         e.req, cmd_code, error, error_reason, e.code, (e.why != 0), e.why);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        all_chk(12'h000, "R12");
        n_checks++;
        if (error !== 1'b0) begin
            n_fails++;
            $display("FAIL R12 error actual=%b expected=0", error);
        end

        iss(3, 0, 1'b0, 1, "R3");          // read to idle bank
        iss(8, 0, 1'b0, 0, "R9");          // mode set
        iss(5, 0, 1'b0, 5, "R9");          // too soon after mode set
        iss(5, 0, 1'b0, 0, "R9");          // m: activate bank 0
        iss(5, 1, 1'b0, 4, "R7");          // m+1: tRRD violated
        st_chk(0, 1, "R4");
        st_chk(1, 0, "R11");               // rejected activate left bank 1 idle
        iss(3, 0, 1'b0, 2, "R3");          // m+2: tRCD not met
        iss(3, 0, 1'b0, 0, "R4");          // m+3: first legal read
        st_chk(0, 2, "R4");
        iss(5, 1, 1'b0, 0, "R7");          // m+4
        iss(6, 0, 1'b0, 3, "R6");          // m+5: tRAS not met
        iss(7, 0, 1'b0, 6, "R8");          // m+6: refresh with open banks
        nop(1);                            // m+7
        iss(6, 0, 1'b0, 0, "R6");          // m+8: precharge at tRAS
        st_chk(0, 3, "R5");
        st_chk(1, 2, "R5");
        iss(5, 0, 1'b0, 1, "R5");          // m+9: bank closing
        nop(1);                            // m+10
        iss(5, 0, 1'b0, 0, "R5");          // p=m+11: tRP elapsed
        iss(6, 2, 1'b1, 3, "R6");          // all-bank precharge, bank 0 young
        nop(6);
        iss(6, 3, 1'b1, 0, "R5");          // p+8: all-bank precharge, BA ignored
        st_chk(0, 3, "R5");
        st_chk(1, 3, "R5");
        nop(3);
        all_chk(12'h000, "R5");
        iss(6, 2, 1'b0, 0, "R5");          // precharge of idle bank
        st_chk(2, 0, "R5");
        iss(5, 3, 1'b0, 0, "R2", 1'b0);    // activate with CKE low
        iss(3, 3, 1'b0, 0, "R2", 1'b0);    // read with CKE low
        st_chk(3, 0, "R2");
        iss(7, 0, 1'b0, 0, "R8");          // q: refresh
        all_chk(12'b100_100_100_100, "R8");
        iss(5, 0, 1'b0, 1, "R8");          // q+1
        nop(10);
        iss(5, 0, 1'b0, 1, "R8");          // q+12: still refreshing
        iss(5, 0, 1'b0, 0, "R8");          // q+13: tRFC elapsed
        st_chk(0, 1, "R4");
        nop(2);
        iss(3, 0, 1'b1, 0, "R10");         // q+16: read with auto-precharge
        st_chk(0, 3, "R10");
        nop(3);
        iss(8, 0, 1'b0, 0, "R9");          // mode set, all idle
        iss(3, 0, 1'b0, 5, "R11");         // tMRD outranks bank state
        nop(1);
        iss(2, 0, 1'b0, 0, "R1");          // burst stop
        iss(0, 0, 1'b0, 0, "R1");          // deselect
        iss(4, 1, 1'b0, 1, "R1");          // write to idle bank
        nop(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule